// File: doc/BRIEF.md
# One-Hot Lamp Selector

This block lights exactly one lamp out of a bank of indicator lamps. Software puts a lamp number in a byte-wide transmit register by writing that register's I/O address. A separate apply strobe, which comes from an output-port write, then moves the light. On that strobe the lamp that was lit goes dark, the selected lamp lights, and the selected lamp becomes the current one.

The top bit of the stored byte is a flag. It is removed before the number is used. The stripped byte is also stored back into the register. A number beyond the last lamp is refused: the lamp that is already lit stays lit, and the output neither blanks nor wraps.

One extra output bit, above the selectable bank, is an operator lamp. It follows its own input and is never touched by the selection.

Top module: `lamp_pick`

## Requirements
- R1: While reset is asserted, and after it is released, lamp 0 is the only selectable lamp lit (`lamps[36:0]` equals 1).
- R2: A write with `wr_addr` equal to 8'h0B stores `wr_data` in the transmit register. Writes to any other address leave the register unchanged, so the next apply lights the lamp the earlier byte chose.
- R3: `lamps[36:0]` changes only in the clock cycle after an edge at which `apply` is high. A register write alone never changes the outputs.
- R4: On apply, bit 7 of the stored byte is cleared. Bits 6:0 then give the lamp number, so a byte of 8'h80+n selects lamp n for n from 0 to 36.
- R5: On apply, a stripped number of 37 or more leaves the current lamp lit and unchanged.
- R6: Exactly one bit of `lamps[36:0]` is set at all times.
- R7: `lamps[37]` equals `op_lamp` at all times, whatever the selection is doing.
- R8: When a register write and an apply share an edge, the apply uses the byte held before that edge. The new byte takes effect on the next apply, and repeating an apply with no new write keeps the same lamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | I/O register write strobe |
| wr_addr | input | 8 | I/O write address |
| wr_data | input | 8 | I/O write data |
| apply | input | 1 | Strobe that moves the light to the stored lamp number |
| op_lamp | input | 1 | Operator lamp drive |
| lamps | output | 38 | Bits 36:0 are the one-hot selection; bit 37 is the operator lamp |

## Verification
The hardest case is the rejection path. An out-of-range number only shows that it was refused if some other lamp is already lit, so each refused byte has to follow a write and apply that moved the light away from lamp 0. The stimulus sweeps all 256 byte values in order. In-range values move the light, and every rejected value then meets a recently chosen non-zero lamp. The flagged forms of the same numbers are covered by the same sweep. Writes to every other address and writes that coincide with an apply are added on top of that sequence.

// File: rtl/lamp_pick.sv
module lamp_pick #(
  parameter int NUM_LAMPS = 37,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter bit [ADDR_W-1:0] SEL_ADDR = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              apply,
  input  logic              op_lamp,
  output logic [NUM_LAMPS:0] lamps
);
  localparam int IDX_W = $clog2(NUM_LAMPS);
  localparam int FLAG  = DATA_W - 1;

  logic [DATA_W-1:0]    held;
  logic [IDX_W-1:0]     cur;
  logic [NUM_LAMPS-1:0] ring;

  wire              hit  = wr_en && (wr_addr == SEL_ADDR);
  wire [DATA_W-1:0] bare = {1'b0, held[FLAG-1:0]};
  wire              fits = bare < DATA_W'(NUM_LAMPS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held <= '0;
      cur  <= '0;
    end else begin
      if (hit)        held <= wr_data;
      else if (apply) held <= bare;
      if (apply && fits) cur <= bare[IDX_W-1:0];
    end

  assign ring  = NUM_LAMPS'(1) << cur;
  assign lamps = {op_lamp, ring};
endmodule

module lamp_pick_chk #(
  parameter int NUM_LAMPS = 37,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              apply,
  input logic [DATA_W-1:0] held,
  input logic [NUM_LAMPS:0] lamps
);
  wire [NUM_LAMPS-1:0] ring = lamps[NUM_LAMPS-1:0];
  wire [DATA_W-2:0]    num  = held[DATA_W-2:0];

  assert_reset_lamp0_R1: assert property (@(posedge clk)
    !rst_n |=> ring == NUM_LAMPS'(1));

  assert_quiet_without_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(ring));

  assert_pick_stripped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apply && (num < NUM_LAMPS) |=> ring == (NUM_LAMPS'(1) << $past(num)));

  assert_reject_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    apply && (num >= NUM_LAMPS) |=> $stable(ring));

  assert_one_lit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring) == 1);
endmodule

bind lamp_pick lamp_pick_chk #(.NUM_LAMPS(NUM_LAMPS), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .apply(apply), .held(held), .lamps(lamps)
);

// File: tb/lamp_pick_test.sv
`timescale 1ns/1ps
module lamp_pick_test;
  localparam int N = 37;
  logic clk = 0, rst_n = 0, wr_en = 0, apply = 0, op_lamp = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [N:0] lamps;
  int vecs = 0, bad = 0, exp_cur = 0;
  logic [7:0] exp_held = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lamp_pick uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .apply(apply), .op_lamp(op_lamp), .lamps(lamps));

  task automatic check(string req);
    logic [N:0] exp;
    exp = {op_lamp, N'(1) << exp_cur};
    vecs++;
    if (lamps !== exp) begin
      bad++;
      $display("FAIL %s: lamps=%h expected=%h", req, lamps, exp);
    end
  endtask

  task automatic model_apply();
    logic [7:0] s;
    s = {1'b0, exp_held[6:0]};
    if (s < N) exp_cur = int'(s);
    exp_held = s;
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d, input bit ap);
    wr_en = w; wr_addr = a; wr_data = d; apply = ap;
    @(posedge clk); #1;
    wr_en = 0; apply = 0;
    if (ap) model_apply();
    if (w && a == 8'h0B) exp_held = d;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; check("R1");
    rst_n = 1;
    @(posedge clk); #1; check("R1");

    for (int d = 0; d < 256; d++) begin
      op_lamp = d[1];
      step(1, 8'h0B, 8'(d), 0); check("R3");
      step(0, 8'h00, 8'h00, 1);
      if (d[6:0] >= N) check("R5"); else check("R4");
    end

    step(1, 8'h0B, 8'd20, 0);
    step(0, 0, 0, 1); check("R2");
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h0B) continue;
      step(1, 8'(a), 8'(a % 37), 0); check("R3");
      step(0, 0, 0, 1); check("R2");
    end

    for (int k = 0; k < 37; k++) begin
      step(1, 8'h0B, 8'(k), 1); check("R8");
      step(0, 0, 0, 1); check("R8");
      step(0, 0, 0, 1); check("R8");
    end

    for (int t = 0; t < 4; t++) begin
      op_lamp = ~op_lamp; #1; check("R7");
    end

    step(1, 8'h0B, 8'd9, 1);
    step(0, 0, 0, 1); check("R4");
    rst_n = 0; #1; exp_cur = 0; exp_held = 0; check("R1");
    @(posedge clk); #1; rst_n = 1;
    @(posedge clk); #1; check("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule